// File: doc/BRIEF.md
# Stride Value Predictor Table

This block guesses the result an instruction is about to produce. It keeps a small table that is indexed by the instruction address. Each slot holds the last result seen for one instruction, the difference between its two most recent results, and a confidence level. A front-end stage presents an address on the lookup side. In the same cycle it receives a predicted value equal to the stored last result plus the stored difference. It also receives a hit flag and a flag that says whether the prediction is trustworthy enough to use.

When the instruction later completes, the back end presents the address and the real result on the update side. The slot is then refreshed at the next rising clock edge. If the stored tag does not match, the slot is taken over for the new instruction and starts with a zero difference. If the tag matches, a new difference is computed and compared with the stored one.

Confidence is a four-state machine per slot. The states are COLD, WARM, HOT and SAT. The transitions are: `step` (COLD to WARM, WARM to HOT, HOT to SAT), `hold` (SAT to SAT), and `drop` (any state to COLD). A `step` or `hold` happens when a hit update repeats the stored difference. A `drop` happens on any other hit update and on every allocation. Predictions are marked usable in HOT and SAT only.

Top module: `svp_table`

## Requirements
- R1: After reset, and after any later reset, every slot is empty: each lookup returns hit 0, usable 0 and value 0 until that slot is next written.
- R2: The slot is selected by address bits [7:2]. The tag is address bits [31:8]. Address bits [1:0] are ignored. Two addresses that share bits [7:2] but differ in the tag compete for one slot, and writing one evicts the other.
- R3: An update whose tag misses its slot allocates the slot: last result = actual value, difference = 0, state COLD. A following lookup of that address hits and returns the actual value.
- R4: An update whose tag hits sets the difference to (actual − stored last) and the last result to actual. A lookup returns last + difference.
- R5: On a hit update, the confidence follows `step`/`hold` when the new difference equals the stored one, and `drop` otherwise. An allocating update puts the slot in COLD.
- R6: The usable flag is 1 only when the lookup hits and the slot is in HOT or SAT.
- R7: Differences and predictions are computed modulo 2^32. For example, last 0xFFFFFFF8 with difference 8 predicts 0.
- R8: A lookup and an update in the same cycle on the same slot return the state from before that update.
- R9: An update to one slot leaves every other slot's lookup result unchanged.
- R10: With no update and a steady lookup address, the lookup outputs stay unchanged from cycle to cycle.
- R11: On a lookup miss the predicted value output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | 32 | Address of the instruction being looked up |
| lk_hit | output | 1 | Slot holds this address's tag |
| lk_pred_ok | output | 1 | Prediction is confident enough to use |
| lk_value | output | 32 | Predicted result (0 on miss) |
| up_en | input | 1 | Apply an update this cycle |
| up_pc | input | 32 | Address of the completing instruction |
| up_value | input | 32 | Actual result it produced |

## Verification
The bench builds the block with its default parameters: 64 slots, 32-bit addresses and 32-bit values. With these settings the slot field is bits [7:2]. Addresses 0x1004 and 0x2004 therefore collide in one slot, and a 32-bit value sequence crossing 0xFFFFFFFF exercises the wraparound of both the subtraction and the addition. Full-width values also allow negative differences to be tested with a descending sequence. The size allows all four confidence states, saturation, and a `drop` after SAT to be driven on one slot within a few dozen cycles.

// File: rtl/svp_pkg.sv
package svp_pkg;

    // Confidence level of one table slot
    typedef enum logic [1:0] {
        CONF_COLD = 2'd0,
        CONF_WARM = 2'd1,
        CONF_HOT  = 2'd2,
        CONF_SAT  = 2'd3
    } conf_e;

endpackage

// File: rtl/svp_pc_split.sv
module svp_pc_split #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    localparam int TAG_W = PC_W - IDX_W - 2
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);

    // Word-aligned instructions: the two lowest address bits carry no information
    assign idx = pc[IDX_W+1:2];
    assign tag = pc[PC_W-1:IDX_W+2];

endmodule

// File: rtl/svp_next_state.sv
module svp_next_state
    import svp_pkg::*;
#(
    parameter int VAL_W = 32
) (
    input  logic             hit,
    input  logic [VAL_W-1:0] old_last,
    input  logic [VAL_W-1:0] old_stride,
    input  conf_e            old_conf,
    input  logic [VAL_W-1:0] actual,
    output logic [VAL_W-1:0] nxt_last,
    output logic [VAL_W-1:0] nxt_stride,
    output conf_e            nxt_conf
);

    logic [VAL_W-1:0] diff;

    assign diff = actual - old_last;

    // Data fields of the slot
    always_comb begin
        nxt_last = actual;
        if (hit) begin
            nxt_stride = diff;
        end else begin
            nxt_stride = '0;
        end
    end

    // Confidence state transitions: step / hold / drop
    always_comb begin
        nxt_conf = CONF_COLD;
        if (hit && (diff == old_stride)) begin
            unique case (old_conf)
                CONF_COLD: nxt_conf = CONF_WARM;
                CONF_WARM: nxt_conf = CONF_HOT;
                CONF_HOT:  nxt_conf = CONF_SAT;
                CONF_SAT:  nxt_conf = CONF_SAT;
                default:   nxt_conf = CONF_COLD;
            endcase
        end
    end

endmodule

// File: rtl/svp_store.sv
module svp_store
    import svp_pkg::*;
#(
    parameter int ENTRIES  = 64,
    parameter int TAG_W    = 24,
    parameter int VAL_W    = 32,
    parameter int RD_PORTS = 2,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [VAL_W-1:0] wr_last,
    input  logic [VAL_W-1:0] wr_stride,
    input  conf_e            wr_conf,
    input  logic [IDX_W-1:0] rd_idx    [RD_PORTS],
    output logic             rd_vld    [RD_PORTS],
    output logic [TAG_W-1:0] rd_tag    [RD_PORTS],
    output logic [VAL_W-1:0] rd_last   [RD_PORTS],
    output logic [VAL_W-1:0] rd_stride [RD_PORTS],
    output conf_e            rd_conf   [RD_PORTS]
);

    logic             vld_q    [ENTRIES];
    logic [TAG_W-1:0] tag_q    [ENTRIES];
    logic [VAL_W-1:0] last_q   [ENTRIES];
    logic [VAL_W-1:0] stride_q [ENTRIES];
    conf_e            conf_q   [ENTRIES];

    // State register: one write per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                vld_q[e]    <= 1'b0;
                tag_q[e]    <= '0;
                last_q[e]   <= '0;
                stride_q[e] <= '0;
                conf_q[e]   <= CONF_COLD;
            end
        end else if (wr_en) begin
            vld_q[wr_idx]    <= 1'b1;
            tag_q[wr_idx]    <= wr_tag;
            last_q[wr_idx]   <= wr_last;
            stride_q[wr_idx] <= wr_stride;
            conf_q[wr_idx]   <= wr_conf;
        end
    end

    // Read ports see the registered state, i.e. the state before this cycle's write
    for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
        always_comb begin
            rd_vld[p]    = vld_q[rd_idx[p]];
            rd_tag[p]    = tag_q[rd_idx[p]];
            rd_last[p]   = last_q[rd_idx[p]];
            rd_stride[p] = stride_q[rd_idx[p]];
            rd_conf[p]   = conf_q[rd_idx[p]];
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (vld_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag))); // R3

endmodule

// File: rtl/svp_table.sv
module svp_table
    import svp_pkg::*;
#(
    parameter int ENTRIES = 64,
    parameter int PC_W    = 32,
    parameter int VAL_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int TAG_W  = PC_W - IDX_W - 2,
    localparam int P_LK   = 0,
    localparam int P_UP   = 1,
    localparam int NPORT  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_hit,
    output logic             lk_pred_ok,
    output logic [VAL_W-1:0] lk_value,
    input  logic             up_en,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [VAL_W-1:0] up_value
);

    logic [PC_W-1:0]  port_pc   [NPORT];
    logic [IDX_W-1:0] port_idx  [NPORT];
    logic [TAG_W-1:0] port_tag  [NPORT];
    logic             rd_vld    [NPORT];
    logic [TAG_W-1:0] rd_tag    [NPORT];
    logic [VAL_W-1:0] rd_last   [NPORT];
    logic [VAL_W-1:0] rd_stride [NPORT];
    conf_e            rd_conf   [NPORT];
    logic             port_hit  [NPORT];

    logic [VAL_W-1:0] nxt_last;
    logic [VAL_W-1:0] nxt_stride;
    conf_e            nxt_conf;

    assign port_pc[P_LK] = lk_pc;
    assign port_pc[P_UP] = up_pc;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        svp_pc_split #(.PC_W(PC_W), .IDX_W(IDX_W)) u_split (
            .pc  (port_pc[p]),
            .idx (port_idx[p]),
            .tag (port_tag[p])
        );
        assign port_hit[p] = rd_vld[p] && (rd_tag[p] == port_tag[p]);
    end

    svp_store #(
        .ENTRIES  (ENTRIES),
        .TAG_W    (TAG_W),
        .VAL_W    (VAL_W),
        .RD_PORTS (NPORT)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (up_en),
        .wr_idx    (port_idx[P_UP]),
        .wr_tag    (port_tag[P_UP]),
        .wr_last   (nxt_last),
        .wr_stride (nxt_stride),
        .wr_conf   (nxt_conf),
        .rd_idx    (port_idx),
        .rd_vld    (rd_vld),
        .rd_tag    (rd_tag),
        .rd_last   (rd_last),
        .rd_stride (rd_stride),
        .rd_conf   (rd_conf)
    );

    svp_next_state #(.VAL_W(VAL_W)) u_next (
        .hit        (port_hit[P_UP]),
        .old_last   (rd_last[P_UP]),
        .old_stride (rd_stride[P_UP]),
        .old_conf   (rd_conf[P_UP]),
        .actual     (up_value),
        .nxt_last   (nxt_last),
        .nxt_stride (nxt_stride),
        .nxt_conf   (nxt_conf)
    );

    // Output process: prediction from the pre-update state
    always_comb begin
        lk_hit     = port_hit[P_LK];
        lk_pred_ok = 1'b0;
        lk_value   = '0;
        if (port_hit[P_LK]) begin
            lk_value = rd_last[P_LK] + rd_stride[P_LK];
            unique case (rd_conf[P_LK])
                CONF_HOT, CONF_SAT:   lk_pred_ok = 1'b1;
                CONF_COLD, CONF_WARM: lk_pred_ok = 1'b0;
                default:              lk_pred_ok = 1'b0;
            endcase
        end
    end

    AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!lk_hit && !lk_pred_ok)); // R1

    AST_OK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        lk_pred_ok |-> lk_hit); // R6

    AST_UPD_THEN_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(up_en) && lk_pc[PC_W-1:2] == $past(up_pc[PC_W-1:2])) |-> lk_hit); // R3

    AST_CONF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        up_en |-> (nxt_conf == CONF_COLD
                   || (rd_conf[P_UP] == CONF_SAT && nxt_conf == CONF_SAT)
                   || (int'(nxt_conf) == int'(rd_conf[P_UP]) + 1))); // R5

    AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(up_en) && $stable(lk_pc))
            |-> ($stable(lk_hit) && $stable(lk_pred_ok) && $stable(lk_value))); // R10

endmodule

// File: tb/sim_svp_table.sv
module sim_svp_table;

    localparam logic [31:0] PA = 32'h0000_1004;  // slot 1
    localparam logic [31:0] PB = 32'h0000_2004;  // slot 1, other tag
    localparam logic [31:0] PC = 32'h0000_1008;  // slot 2
    localparam logic [31:0] PD = 32'h0000_100C;  // slot 3
    localparam logic [31:0] PE = 32'h0000_1010;  // slot 4
    localparam int NVEC = 24;

    // {up_en, up_pc, up_value, lk_pc, exp_hit, exp_ok, exp_value}
    localparam logic [130:0] VEC [NVEC] = '{
        {1'b1, PA, 32'd100, PA, 1'b0, 1'b0, 32'd0},          // 0  R1 R3 R11 allocate A
        {1'b1, PA, 32'd110, PA, 1'b1, 1'b0, 32'd100},        // 1  R3 R8
        {1'b1, PA, 32'd120, PA, 1'b1, 1'b0, 32'd120},        // 2  R4 stride 10
        {1'b1, PA, 32'd130, PA, 1'b1, 1'b0, 32'd130},        // 3  R5 WARM
        {1'b1, PA, 32'd140, PA, 1'b1, 1'b1, 32'd140},        // 4  R6 HOT
        {1'b1, PA, 32'd150, PA, 1'b1, 1'b1, 32'd150},        // 5  R5 SAT
        {1'b1, PA, 32'd200, PA, 1'b1, 1'b1, 32'd160},        // 6  R5 hold, then drop
        {1'b0, 32'd0, 32'd0, PA, 1'b1, 1'b0, 32'd250},       // 7  R5 R6 after drop
        {1'b1, PC, 32'd5, PA, 1'b1, 1'b0, 32'd250},          // 8  R9 other slot written
        {1'b0, 32'd0, 32'd0, PC, 1'b1, 1'b0, 32'd5},         // 9  R3
        {1'b0, 32'd0, 32'd0, PA | 32'd1, 1'b1, 1'b0, 32'd250}, // 10 R2 low bits ignored
        {1'b1, PB, 32'd7, PB, 1'b0, 1'b0, 32'd0},            // 11 R2 R11 tag miss
        {1'b0, 32'd0, 32'd0, PA, 1'b0, 1'b0, 32'd0},         // 12 R2 evicted
        {1'b0, 32'd0, 32'd0, PB, 1'b1, 1'b0, 32'd7},         // 13 R2
        {1'b1, PD, 32'hFFFF_FFF0, PD, 1'b0, 1'b0, 32'd0},    // 14 R7
        {1'b1, PD, 32'hFFFF_FFF8, PD, 1'b1, 1'b0, 32'hFFFF_FFF0}, // 15 R7
        {1'b1, PD, 32'd0, PD, 1'b1, 1'b0, 32'd0},            // 16 R7 wrap of add
        {1'b1, PD, 32'd8, PD, 1'b1, 1'b0, 32'd8},            // 17 R7 wrap of subtract
        {1'b0, 32'd0, 32'd0, PD, 1'b1, 1'b1, 32'd16},        // 18 R7 R6
        {1'b1, PE, 32'd50, PE, 1'b0, 1'b0, 32'd0},           // 19 R3
        {1'b1, PE, 32'd40, PE, 1'b1, 1'b0, 32'd50},          // 20 R4
        {1'b1, PE, 32'd30, PE, 1'b1, 1'b0, 32'd30},          // 21 R4 negative stride
        {1'b1, PE, 32'd20, PE, 1'b1, 1'b0, 32'd20},          // 22 R5
        {1'b0, 32'd0, 32'd0, PE, 1'b1, 1'b1, 32'd10}         // 23 R6
    };

    logic        clk;
    logic        rst_n;
    logic [31:0] lk_pc;
    logic        lk_hit;
    logic        lk_pred_ok;
    logic [31:0] lk_value;
    logic        up_en;
    logic [31:0] up_pc;
    logic [31:0] up_value;

    int n_chk;
    int n_bad;
    bit done;

    svp_table u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .lk_pc      (lk_pc),
        .lk_hit     (lk_hit),
        .lk_pred_ok (lk_pred_ok),
        .lk_value   (lk_value),
        .up_en      (up_en),
        .up_pc      (up_pc),
        .up_value   (up_value)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_lk(input string req, input logic eh, input logic eo,
                            input logic [31:0] ev);
        check(req, "lk_hit", {31'd0, lk_hit}, {31'd0, eh});
        check(req, "lk_pred_ok", {31'd0, lk_pred_ok}, {31'd0, eo});
        check(req, "lk_value", lk_value, ev);
    endtask

    // Drive at the falling edge; the lookup reflects state before this cycle's update
    task automatic drive(input logic ue, input logic [31:0] upc,
                         input logic [31:0] uv, input logic [31:0] lpc);
        @(negedge clk);
        up_en    = ue;
        up_pc    = upc;
        up_value = uv;
        lk_pc    = lpc;
        #2;
    endtask

    initial begin
        n_chk = 0; n_bad = 0; done = 1'b0;
        rst_n = 1'b0; up_en = 1'b0; up_pc = '0; up_value = '0; lk_pc = PA;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        drive(1'b0, 32'd0, 32'd0, PA);
        check_lk("R1 reset", 1'b0, 1'b0, 32'd0);

        for (int i = 0; i < NVEC; i++) begin
            logic [130:0] v;
            string tagstr;
            v = VEC[i];
            drive(v[130], v[129:98], v[97:66], v[65:34]);
            tagstr = $sformatf("R8 table row %0d", i);
            check_lk(tagstr, v[33], v[32], v[31:0]);
        end

        // R10: steady lookup, no update, two cycles
        drive(1'b0, 32'd0, 32'd0, PD);
        check_lk("R10 first", 1'b1, 1'b1, 32'd16);
        drive(1'b0, 32'd0, 32'd0, PD);
        check_lk("R10 second", 1'b1, 1'b1, 32'd16);

        // R8: same-cycle update and lookup on D (stride 8, HOT)
        drive(1'b1, PD, 32'd16, PD);
        check_lk("R8 same cycle", 1'b1, 1'b1, 32'd16);
        drive(1'b0, 32'd0, 32'd0, PD);
        check_lk("R8 after commit", 1'b1, 1'b1, 32'd24);

        // R1: reset mid-run clears every slot
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 32'd0, 32'd0, PD);
        check_lk("R1 after reset D", 1'b0, 1'b0, 32'd0);
        drive(1'b0, 32'd0, 32'd0, PB);
        check_lk("R1 after reset B", 1'b0, 1'b0, 32'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule